// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Unit

This block tracks which lanes of one 32-lane warp are enabled while the warp runs a single shared instruction stream. Each cycle the issue logic reports one of four events: a warp launch, a conditional branch, a plain advance to the next instruction, or nothing. The block answers with the program counter and lane mask for the next issued instruction. Enabled lanes execute that instruction. Disabled lanes must not commit results.

A branch carries a per-lane predicate and three addresses: the target, the fall-through and the reconvergence point. If every enabled lane agrees on the direction, the warp takes that one path at no extra cost. If the lanes disagree, the block serialises the two paths. It first runs the taken lanes. When the PC reaches the reconvergence point, it runs the fall-through lanes. When the PC reaches that point again, it restores the mask that was active before the branch. A stack of pending regions, whose depth is a parameter, lets divergent branches nest.

The issue logic must give a nested region a reconvergence point that differs from the one of the region enclosing it. The block pops at most one level per cycle.

Top module: `simt_div_unit`

## Requirements
- R1: After reset the PC equals parameter RESET_PC, all LANES mask bits are 1, the overflow flag is 0 and the stack is empty.
- R2: A launch loads the PC and the mask from launch_pc and launch_mask and empties the stack. Launch takes priority over a branch, and a branch takes priority over an advance. Reaching an address that an earlier region used as its reconvergence point has no effect after a launch.
- R3: A branch with a non-zero active mask, where every active lane has its predicate bit at 1, moves the PC to the target and leaves the mask unchanged. Predicate bits of inactive lanes are ignored.
- R4: A branch with a non-zero active mask, where every active lane has its predicate bit at 0, moves the PC to the fall-through address and leaves the mask unchanged.
- R5: A branch issued with an all-zero active mask only moves the PC to the fall-through address. The mask stays zero.
- R6: A divergent branch whose target differs from its reconvergence point moves the PC to the target and sets the mask to predicate AND active mask. It pushes a stack entry. No mask bit is ever gained except on a launch, a switch to the fall-through pass, or a pop.
- R7: When the next PC equals the reconvergence point of the top entry, and its fall-through pass is still pending, the PC goes to the fall-through address and the mask becomes (NOT predicate) AND the pre-branch mask.
- R8: When the next PC equals the reconvergence point of the top entry, and its fall-through pass is done or empty, the entry is popped, the PC stays at the reconvergence point, and the full pre-branch mask is restored.
- R9: A divergent branch whose target equals its reconvergence point starts the fall-through pass at once. If the fall-through address also equals it, the PC goes to the reconvergence point with the mask unchanged and nothing is pushed.
- R10: Divergent branches nest up to DEPTH levels. Each level restores its own pre-branch mask in last-in, first-out order.
- R11: A divergent branch that arrives with DEPTH entries on the stack is dropped. The PC goes to the fall-through address, the mask is unchanged, and the overflow flag is set. The flag stays set until reset, and a launch does not clear it.
- R12: Advance increments the PC by one. With no event the PC and the mask hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch | input | 1 | Start a warp at launch_pc with launch_mask |
| launch_pc | input | PCW | Start address |
| launch_mask | input | LANES | Initial lane mask |
| adv | input | 1 | Non-branch instruction issued, move to PC+1 |
| br_valid | input | 1 | Conditional branch issued at the current PC |
| br_pred | input | LANES | Per-lane condition, 1 means taken |
| br_target | input | PCW | Taken-path address |
| br_fall | input | PCW | Fall-through address |
| br_reconv | input | PCW | Reconvergence address |
| pc_o | output | PCW | PC of the next issued instruction |
| mask_o | output | LANES | Lanes enabled for that instruction |
| overflow_o | output | 1 | Sticky flag for a stack overflow |

## Verification
The hardest state to reach from the ports is a full stack that receives one more divergent branch. Reaching it needs DEPTH nested splits, each with a non-empty taken side, a non-empty fall-through side and its own reconvergence address. The stimulus builds this by clearing one more lane per level with a predicate of all ones except a single bit. This leaves exactly one fall-through lane per level. The ninth split then meets the full stack. A launch afterwards steps onto an address that a dropped region used as its reconvergence point, which shows that the stack was cleared.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

   // Classification of one branch against the active mask
   typedef enum logic [1:0] {
      BK_NOP       = 2'd0,   // no active lane
      BK_TAKEN     = 2'd1,   // every active lane taken
      BK_NOT_TAKEN = 2'd2,   // no active lane taken
      BK_SPLIT     = 2'd3    // active lanes disagree
   } br_kind_e;

endpackage

// File: rtl/simt_br_classify.sv
module simt_br_classify
   import simt_div_pkg::*;
#(
   parameter int LANES = 32
) (
   input  logic [LANES-1:0] act_mask,
   input  logic [LANES-1:0] pred,
   output logic [LANES-1:0] then_mask,
   output logic [LANES-1:0] else_mask,
   output br_kind_e         kind
);

   assign then_mask = pred & act_mask;
   assign else_mask = ~pred & act_mask;

   always_comb begin
      if (act_mask == '0)       kind = BK_NOP;
      else if (else_mask == '0) kind = BK_TAKEN;
      else if (then_mask == '0) kind = BK_NOT_TAKEN;
      else                      kind = BK_SPLIT;
   end

endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack #(
   parameter int DEPTH = 8,
   parameter int EW    = 97,   // entry width, bit 0 is the pass-done flag
   localparam int DW   = $clog2(DEPTH + 1),
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic          mark,
   input  logic [EW-1:0] push_data,
   output logic [EW-1:0] top_data,
   output logic [DW-1:0] depth,
   output logic          empty,
   output logic          full
);

   logic [DW-1:0] sp_q;
   logic [DW-1:0] top_idx;
   logic [EW-1:0] slot_rd [DEPTH];

   assign depth   = sp_q;
   assign empty   = (sp_q == '0);
   assign full    = (sp_q == DW'(DEPTH));
   assign top_idx = sp_q - DW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sp_q <= '0;
      else if (clr)              sp_q <= '0;
      else if (push && !full)    sp_q <= sp_q + DW'(1);
      else if (pop && !empty)    sp_q <= sp_q - DW'(1);
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic [EW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (!clr && push && !full && sp_q == DW'(s))
            q <= push_data;
         else if (!clr && mark && sp_q == DW'(s + 1))
            q[0] <= 1'b1;
      end
      assign slot_rd[s] = q;
   end

   assign top_data = empty ? '0 : slot_rd[top_idx[IW-1:0]];

endmodule

// File: rtl/simt_div_unit.sv
module simt_div_unit
   import simt_div_pkg::*;
#(
   parameter int          LANES    = 32,
   parameter int          PCW      = 16,
   parameter int          DEPTH    = 8,
   parameter logic [15:0] RESET_PC = 16'h0000,
   localparam int         EW       = 2 * LANES + 2 * PCW + 1,
   localparam int         DW       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [PCW-1:0]   launch_pc,
   input  logic [LANES-1:0] launch_mask,
   input  logic             adv,
   input  logic             br_valid,
   input  logic [LANES-1:0] br_pred,
   input  logic [PCW-1:0]   br_target,
   input  logic [PCW-1:0]   br_fall,
   input  logic [PCW-1:0]   br_reconv,
   output logic [PCW-1:0]   pc_o,
   output logic [LANES-1:0] mask_o,
   output logic             overflow_o
);

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (PCW < 2) begin : g_bad_pcw
      $error("PCW must be at least 2");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end

   typedef struct packed {
      logic [LANES-1:0] full_m;
      logic [LANES-1:0] else_m;
      logic [PCW-1:0]   fall;
      logic [PCW-1:0]   reconv;
      logic             done;
   } div_ent_t;

   logic [PCW-1:0]   pc_q, pc_n, cand_pc;
   logic [LANES-1:0] mask_q, mask_n, then_m, else_m;
   logic             ovf_q, ovf_set, cand_v;
   br_kind_e         kind;
   logic             stk_push, stk_pop, stk_mark, stk_empty, stk_full;
   logic [DW-1:0]    stk_depth;
   logic [EW-1:0]    top_raw;
   div_ent_t         top_e, push_e;

   simt_br_classify #(.LANES(LANES)) cls_i (
      .act_mask  (mask_q),
      .pred      (br_pred),
      .then_mask (then_m),
      .else_mask (else_m),
      .kind      (kind)
   );

   simt_div_stack #(.DEPTH(DEPTH), .EW(EW)) stk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (launch),
      .push      (stk_push),
      .pop       (stk_pop),
      .mark      (stk_mark),
      .push_data (push_e),
      .top_data  (top_raw),
      .depth     (stk_depth),
      .empty     (stk_empty),
      .full      (stk_full)
   );

   assign top_e = top_raw;

   always_comb begin
      pc_n     = pc_q;
      mask_n   = mask_q;
      stk_push = 1'b0;
      stk_pop  = 1'b0;
      stk_mark = 1'b0;
      ovf_set  = 1'b0;
      push_e   = '0;
      cand_v   = 1'b0;
      cand_pc  = pc_q;
      if (launch) begin
         pc_n   = launch_pc;
         mask_n = launch_mask;
      end else if (br_valid) begin
         unique case (kind)
            BK_NOP, BK_NOT_TAKEN: begin
               cand_v  = 1'b1;
               cand_pc = br_fall;
            end
            BK_TAKEN: begin
               cand_v  = 1'b1;
               cand_pc = br_target;
            end
            default: begin
               if (stk_full) begin
                  ovf_set = 1'b1;
                  cand_v  = 1'b1;
                  cand_pc = br_fall;
               end else if (br_target != br_reconv) begin
                  stk_push = 1'b1;
                  push_e   = '{full_m: mask_q, else_m: else_m, fall: br_fall,
                               reconv: br_reconv, done: 1'b0};
                  pc_n     = br_target;
                  mask_n   = then_m;
               end else if (br_fall != br_reconv) begin
                  stk_push = 1'b1;
                  push_e   = '{full_m: mask_q, else_m: else_m, fall: br_fall,
                               reconv: br_reconv, done: 1'b1};
                  pc_n     = br_fall;
                  mask_n   = else_m;
               end else begin
                  pc_n = br_reconv;
               end
            end
         endcase
      end else if (adv) begin
         cand_v  = 1'b1;
         cand_pc = pc_q + PCW'(1);
      end

      if (cand_v) begin
         pc_n = cand_pc;
         if (!stk_empty && cand_pc == top_e.reconv) begin
            if (!top_e.done && top_e.fall != top_e.reconv) begin
               stk_mark = 1'b1;
               pc_n     = top_e.fall;
               mask_n   = top_e.else_m;
            end else begin
               stk_pop = 1'b1;
               mask_n  = top_e.full_m;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC[PCW-1:0];
         mask_q <= '1;
         ovf_q  <= 1'b0;
      end else begin
         pc_q   <= pc_n;
         mask_q <= mask_n;
         if (ovf_set) ovf_q <= 1'b1;
      end
   end

   assign pc_o       = pc_q;
   assign mask_o     = mask_q;
   assign overflow_o = ovf_q;

endmodule

// File: rtl/simt_div_chk.sv
module simt_div_chk #(
   parameter int  LANES = 32,
   parameter int  PCW   = 16,
   parameter int  DEPTH = 8,
   localparam int DW    = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             launch,
   input logic [PCW-1:0]   launch_pc,
   input logic [LANES-1:0] launch_mask,
   input logic             adv,
   input logic             br_valid,
   input logic [LANES-1:0] br_pred,
   input logic [PCW-1:0]   br_target,
   input logic [PCW-1:0]   br_fall,
   input logic [PCW-1:0]   br_reconv,
   input logic [PCW-1:0]   pc_o,
   input logic [LANES-1:0] mask_o,
   input logic             overflow_o,
   input logic [DW-1:0]    stk_depth,
   input logic             stk_full,
   input logic             stk_pop,
   input logic             stk_mark
);

   AST_LAUNCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (pc_o == $past(launch_pc)) && (mask_o == $past(launch_mask))
                 && (stk_depth == '0)); // R2

   AST_ZERO_MASK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !launch && mask_o == '0)
      |=> (mask_o == '0) && (pc_o == $past(br_fall))); // R5

   AST_SPLIT_THEN: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !launch && !stk_full && br_target != br_reconv
       && (br_pred & mask_o) != '0 && (~br_pred & mask_o) != '0)
      |=> (mask_o == $past(br_pred & mask_o)) && (pc_o == $past(br_target))); // R6

   AST_MASK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && !stk_pop && !stk_mark)
      |=> ((mask_o & ~$past(mask_o)) == '0)); // R6

   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      stk_depth <= DW'(DEPTH)); // R10

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |=> overflow_o); // R11

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && !br_valid && !adv) |=> $stable(pc_o) && $stable(mask_o)); // R12

endmodule

bind simt_div_unit simt_div_chk #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .launch      (launch),
   .launch_pc   (launch_pc),
   .launch_mask (launch_mask),
   .adv         (adv),
   .br_valid    (br_valid),
   .br_pred     (br_pred),
   .br_target   (br_target),
   .br_fall     (br_fall),
   .br_reconv   (br_reconv),
   .pc_o        (pc_o),
   .mask_o      (mask_o),
   .overflow_o  (overflow_o),
   .stk_depth   (stk_depth),
   .stk_full    (stk_full),
   .stk_pop     (stk_pop),
   .stk_mark    (stk_mark)
);

// File: tb/simt_div_unit_tb.sv
module simt_div_unit_tb_top;

   localparam int LANES = 32;
   localparam int PCW   = 16;
   localparam int DEPTH = 8;
   localparam logic [31:0] ALL = 32'hFFFF_FFFF;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             launch = 1'b0;
   logic [PCW-1:0]   launch_pc = '0;
   logic [LANES-1:0] launch_mask = '0;
   logic             adv = 1'b0;
   logic             br_valid = 1'b0;
   logic [LANES-1:0] br_pred = '0;
   logic [PCW-1:0]   br_target = '0;
   logic [PCW-1:0]   br_fall = '0;
   logic [PCW-1:0]   br_reconv = '0;
   logic [PCW-1:0]   pc_o;
   logic [LANES-1:0] mask_o;
   logic             overflow_o;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   simt_div_unit #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pc(launch_pc),
      .launch_mask(launch_mask), .adv(adv), .br_valid(br_valid),
      .br_pred(br_pred), .br_target(br_target), .br_fall(br_fall),
      .br_reconv(br_reconv), .pc_o(pc_o), .mask_o(mask_o),
      .overflow_o(overflow_o)
   );

   // every driving task starts and ends at a falling edge
   task automatic clear_inputs();
      launch = 1'b0; adv = 1'b0; br_valid = 1'b0;
   endtask

   task automatic do_launch(input logic [15:0] pc, input logic [31:0] m);
      launch = 1'b1; launch_pc = pc; launch_mask = m;
      @(negedge clk); clear_inputs();
   endtask

   task automatic do_adv();
      adv = 1'b1;
      @(negedge clk); clear_inputs();
   endtask

   task automatic do_idle();
      @(negedge clk);
   endtask

   task automatic do_br(input logic [31:0] p, input logic [15:0] t,
                        input logic [15:0] f, input logic [15:0] r);
      br_valid = 1'b1; br_pred = p; br_target = t; br_fall = f; br_reconv = r;
      @(negedge clk); clear_inputs();
   endtask

   task automatic chk(input string req, input logic [15:0] epc, input logic [31:0] em);
      total++;
      if (pc_o !== epc || mask_o !== em) begin
         bad++;
         $display("FAIL %s pc=%h exp %h mask=%h exp %h", req, pc_o, epc, mask_o, em);
      end
   endtask

   task automatic chk_ovf(input string req, input logic e);
      total++;
      if (overflow_o !== e) begin
         bad++;
         $display("FAIL %s overflow=%b exp %b", req, overflow_o, e);
      end
   endtask

   task automatic t_reset();
      chk("R1 reset", 16'h0000, ALL);
      chk_ovf("R1 reset", 1'b0);
      do_adv();
      chk("R12 advance", 16'h0001, ALL);
   endtask

   task automatic t_uniform();
      do_launch(16'h0600, 32'h0000_000F);
      chk("R2 launch", 16'h0600, 32'h0000_000F);
      do_br(32'h0000_00FF, 16'h0640, 16'h0601, 16'h0650);
      chk("R3 all taken", 16'h0640, 32'h0000_000F);
      do_br(32'h0000_00F0, 16'h0700, 16'h0641, 16'h0650);
      chk("R4 none taken", 16'h0641, 32'h0000_000F);
      do_idle();
      chk("R12 idle hold", 16'h0641, 32'h0000_000F);
   endtask

   task automatic t_zero_mask();
      do_launch(16'h0500, 32'h0);
      do_br(ALL, 16'h0510, 16'h0501, 16'h0520);
      chk("R5 zero mask", 16'h0501, 32'h0);
   endtask

   task automatic t_split();
      do_launch(16'h0100, ALL);
      do_br(32'h0000_FFFF, 16'h0102, 16'h0101, 16'h0104);
      chk("R6 then pass", 16'h0102, 32'h0000_FFFF);
      do_adv();
      do_adv();
      chk("R7 else pass", 16'h0101, 32'hFFFF_0000);
      do_adv(); do_adv();
      chk("R7 else walk", 16'h0103, 32'hFFFF_0000);
      do_adv();
      chk("R8 restore", 16'h0104, ALL);
   endtask

   task automatic t_empty_paths();
      do_launch(16'h0800, ALL);
      do_br(32'h0000_FFFF, 16'h0810, 16'h0801, 16'h0810);
      chk("R9 empty then", 16'h0801, 32'hFFFF_0000);
      do_br(ALL, 16'h0810, 16'h0802, 16'h0900);
      chk("R8 pop after else", 16'h0810, ALL);
      do_br(32'h0000_00FF, 16'h0820, 16'h0830, 16'h0830);
      chk("R6 then only", 16'h0820, 32'h0000_00FF);
      do_br(ALL, 16'h0830, 16'h0821, 16'h0900);
      chk("R8 empty else pop", 16'h0830, ALL);
      do_br(32'h0000_000F, 16'h0840, 16'h0840, 16'h0840);
      chk("R9 both empty", 16'h0840, ALL);
      do_adv();
      chk("R9 nothing pushed", 16'h0841, ALL);
   endtask

   task automatic t_nested();
      do_launch(16'h0200, ALL);
      do_br(32'h0000_FFFF, 16'h0210, 16'h0201, 16'h0220);
      do_br(32'h0000_00FF, 16'h0212, 16'h0211, 16'h0218);
      chk("R10 inner then", 16'h0212, 32'h0000_00FF);
      do_br(ALL, 16'h0218, 16'h0213, 16'h0300);
      chk("R10 inner else", 16'h0211, 32'h0000_FF00);
      do_br(ALL, 16'h0218, 16'h0212, 16'h0300);
      chk("R10 inner restore", 16'h0218, 32'h0000_FFFF);
      do_br(ALL, 16'h0220, 16'h0219, 16'h0300);
      chk("R10 outer else", 16'h0201, 32'hFFFF_0000);
      do_br(ALL, 16'h0220, 16'h0202, 16'h0300);
      chk("R10 outer restore", 16'h0220, ALL);
   endtask

   task automatic t_overflow();
      logic [31:0] m;
      m = ALL;
      do_launch(16'h0300, ALL);
      for (int k = 0; k < DEPTH; k++) begin
         do_br(~(32'h1 << k), 16'h0301 + 16'(k), 16'h0380 + 16'(k), 16'h03F0 - 16'(k));
         m = m & ~(32'h1 << k);
      end
      chk("R10 full depth", 16'h0308, m);
      chk_ovf("R11 before overflow", 1'b0);
      do_br(~(32'h1 << DEPTH), 16'h0309, 16'h0390, 16'h03E0);
      chk("R11 dropped branch", 16'h0390, m);
      chk_ovf("R11 flag set", 1'b1);
      do_launch(16'h03EF, ALL);
      chk_ovf("R11 sticky over launch", 1'b1);
      do_adv();
      chk("R2 stack cleared", 16'h03F0, ALL);
   endtask

   task automatic t_priority();
      launch = 1'b1; launch_pc = 16'h0A00; launch_mask = 32'h0000_0003;
      br_valid = 1'b1; br_pred = ALL; br_target = 16'h0B00; br_fall = 16'h0B01;
      br_reconv = 16'h0B02; adv = 1'b1;
      @(negedge clk); clear_inputs();
      chk("R2 launch priority", 16'h0A00, 32'h0000_0003);
      br_valid = 1'b1; br_pred = ALL; br_target = 16'h0A40; br_fall = 16'h0A01;
      br_reconv = 16'h0A80; adv = 1'b1;
      @(negedge clk); clear_inputs();
      chk("R2 branch over advance", 16'h0A40, 32'h0000_0003);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_uniform();
      t_zero_mask();
      t_split();
      t_empty_paths();
      t_nested();
      t_overflow();
      t_priority();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule